// File: doc/BRIEF.md
# Tagged Receive Interrupt Coalescer

This block decides when one receive channel should interrupt the host. Each time a message lands in the channel's receive area, a pulse arrives and a batch counter advances. When the batch reaches a programmed message limit, the block raises its interrupt. If fewer messages arrive, the interrupt is raised once a programmed number of 100 µs ticks has passed since the batch began. A link event, such as a transmit page being handed back, is flagged in the batch. A link event alone forces the interrupt on the next tick.

Once the interrupt has fired, the batch is frozen. The block presents a 32-bit status word that the data mover places at the head of the receive area. This word carries a rolling 4-bit tag, the message count and the link flag. Several channels can then share one interrupt line, and the handler can tell which channel raised it. The host re-arms the channel by writing the current tag plus one. Any other tag value is ignored.

Control bits for enable and block reset are changed through separate set and clear addresses. A limits register holds the two thresholds.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: The status word holds the tag in bits 3:0, the message count in bits 10:4 and the link flag in bit 16. All other bits read zero.
- R2: After `rst_n` is low at a clock edge:
  - the status word is zero and the interrupt is low;
  - the block-reset control bit is set and the enable bit is clear;
  - the limits default to 16 messages and 10 ticks.
- R3: Register address 0 sets, and address 1 clears, each control bit whose data bit is 1. Bit 17 is block reset and bit 18 is interrupt enable. All other data bits at these addresses have no effect.
- R4: The interrupt fires at the clock edge that registers a message bringing the count to or above the count limit. A count limit of 0 fires on the first message. Lowering the limit below a pending count fires one cycle after the write.
- R5: A tick advances the batch timer only if a message or link event was already pending before that cycle and the batch is not frozen. The interrupt fires on the tick that brings the timer to the time limit.
- R6: With a link event pending, the next counted tick fires the interrupt whatever the time limit.
- R7: After the interrupt fires, the status word stays frozen until an accepted acknowledge or a block reset. During that time further messages and link events are not recorded.
- R8: A write to address 3 whose bits 3:0 equal the current tag plus one (modulo 16) is an accepted acknowledge. It advances the tag and clears the count, the link flag, the timer and the interrupt. Data bits above 3 are ignored, and the tag wraps from 15 to 0.
- R9: An acknowledge carrying any other tag value changes nothing, and a raised interrupt stays high.
- R10: The interrupt output is the fired state gated by the enable bit. Clearing the enable hides a pending interrupt without losing it.
- R11: While the block-reset bit is set:
  - count, link flag, timer, fired state and tag are held at zero;
  - messages, link events and acknowledges are ignored.
- R12: The message count saturates at 127.
- R13: Register address 2 loads the count limit from bits 7:0 and the time limit from bits 15:8.
- R14: A message or link event in the same cycle as an accepted acknowledge is recorded in the new batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_done | input | 1 | One-cycle pulse: a message was written into the receive area |
| link_done | input | 1 | One-cycle pulse: a link event occurred |
| tick_100us | input | 1 | One-cycle pulse every 100 µs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 set, 1 clear, 2 limits, 3 acknowledge |
| reg_wdata | input | 32 | Register write data |
| irq | output | 1 | Interrupt request |
| status_word | output | 32 | Status word for the head of the receive area |

## Verification
The bench builds the block with its default parameters: a 7-bit count, a 4-bit tag, 8-bit limits, and default thresholds of 16 messages and 10 ticks. With these widths, count saturation is reached after about 130 messages and a full tag wrap after 16 acknowledges. The reset defaults are checked with a plain 16-message batch and a 10-tick timeout. The bench programs small limits (2 messages, 3 ticks), which keeps count, timeout and link-triggered firing within a few cycles. This makes it cheap to cover a tick that coincides with the first message and a message that coincides with an acknowledge.

// File: rtl/icc_pkg.sv
// Package: shared register addresses and bit positions of the interrupt
// coalescer. Assumes a 32-bit register write port.
package icc_pkg;
    typedef enum logic [1:0] {
        ICC_CTL_SET = 2'd0,
        ICC_CTL_CLR = 2'd1,
        ICC_LIMITS  = 2'd2,
        ICC_ACK     = 2'd3
    } icc_addr_e;

    localparam int ICC_REG_W     = 32;
    localparam int ICC_RST_BIT   = 17;
    localparam int ICC_EN_BIT    = 18;
    localparam int ICC_LINK_BIT  = 16;
endpackage

// File: rtl/icc_regs.sv
// Module: control and limits registers plus acknowledge decode.
// Control bits change only through the set/clear addresses. An acknowledge
// is accepted when its low TAG_W bits equal the current tag plus one and the
// block is not held in reset. Assumes 2*LIM_W <= 32.
module icc_regs
    import icc_pkg::*;
#(
    parameter int TAG_W        = 4,
    parameter int LIM_W        = 8,
    parameter int DEF_CNT_LIM  = 16,
    parameter int DEF_TIME_LIM = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [ICC_REG_W-1:0] wr_data,
    input  logic [TAG_W-1:0]     cur_tag,
    output logic                 en,
    output logic                 blk_rst,
    output logic [LIM_W-1:0]     cnt_lim,
    output logic [LIM_W-1:0]     time_lim,
    output logic                 ack_ok
);
    icc_addr_e          addr;
    logic [TAG_W-1:0]   tag_inc;
    logic               unused_wdata;

    assign addr         = icc_addr_e'(wr_addr);
    assign tag_inc      = cur_tag + 1'b1;
    assign unused_wdata = &{1'b0, wr_data};

    // Control bit and limit register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_rst  <= 1'b1;
            en       <= 1'b0;
            cnt_lim  <= LIM_W'(DEF_CNT_LIM);
            time_lim <= LIM_W'(DEF_TIME_LIM);
        end else if (wr_en) begin
            case (addr)
                ICC_CTL_SET: begin
                    if (wr_data[ICC_RST_BIT]) blk_rst <= 1'b1;
                    if (wr_data[ICC_EN_BIT])  en      <= 1'b1;
                end
                ICC_CTL_CLR: begin
                    if (wr_data[ICC_RST_BIT]) blk_rst <= 1'b0;
                    if (wr_data[ICC_EN_BIT])  en      <= 1'b0;
                end
                ICC_LIMITS: begin
                    cnt_lim  <= wr_data[LIM_W-1:0];
                    time_lim <= wr_data[2*LIM_W-1:LIM_W];
                end
                default: ;
            endcase
        end
    end

    // Acknowledge acceptance: right address, expected tag, not in reset
    always_comb begin
        ack_ok = wr_en && (addr == ICC_ACK) && !blk_rst &&
                 (wr_data[TAG_W-1:0] == tag_inc);
    end
endmodule

// File: rtl/icc_batch_counter.sv
// Module: message count and link flag of the current batch.
// clr wipes the batch, restart starts a new batch seeded with this cycle's
// events, and hold freezes the batch. The count saturates at its maximum.
// cnt_nxt is the value the count takes at the next edge.
module icc_batch_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             restart,
    input  logic             hold,
    input  logic             msg,
    input  logic             lnk_evt,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             lnk
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic lnk_nxt;

    // Next batch state by priority: clear, restart, hold, accumulate
    always_comb begin
        cnt_nxt = cnt;
        lnk_nxt = lnk;
        if (clr) begin
            cnt_nxt = '0;
            lnk_nxt = 1'b0;
        end else if (restart) begin
            cnt_nxt = {{(CNT_W-1){1'b0}}, msg};
            lnk_nxt = lnk_evt;
        end else if (!hold) begin
            if (msg && (cnt != CNT_MAX)) cnt_nxt = cnt + 1'b1;
            if (lnk_evt)                 lnk_nxt = 1'b1;
        end
    end

    // Batch state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            lnk <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            lnk <= lnk_nxt;
        end
    end
endmodule

// File: rtl/icc_timeout.sv
// Module: tick counter of the current batch.
// Counts ticks while run is high and fires timeout on the tick that reaches
// the limit, or on any counted tick while a link event is pending.
// Saturates at its maximum. clr holds it at zero.
module icc_timeout #(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             tick,
    input  logic             lnk,
    input  logic [LIM_W-1:0] tlim,
    output logic             timeout
);
    localparam logic [LIM_W-1:0] T_MAX = {LIM_W{1'b1}};

    logic [LIM_W-1:0] elapsed;
    logic [LIM_W:0]   elapsed_inc;

    assign elapsed_inc = {1'b0, elapsed} + 1'b1;

    // Expiry decision for the current cycle
    always_comb begin
        timeout = tick && run && (lnk || (elapsed_inc >= {1'b0, tlim}));
    end

    // Elapsed tick count
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            elapsed <= '0;
        else if (tick && run && (elapsed != T_MAX))
            elapsed <= elapsed_inc[LIM_W-1:0];
    end
endmodule

// File: rtl/irq_coalesce_ctrl.sv
// Module: top of the tagged receive interrupt coalescer.
// Joins the registers, the batch counter and the timeout counter, holds the
// fired state and the rolling tag, and assembles the status word.
// Assumes TAG_W + CNT_W <= 16 so the count sits below the link bit.
module irq_coalesce_ctrl
    import icc_pkg::*;
#(
    parameter int CNT_W        = 7,
    parameter int TAG_W        = 4,
    parameter int LIM_W        = 8,
    parameter int DEF_CNT_LIM  = 16,
    parameter int DEF_TIME_LIM = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        msg_done,
    input  logic        link_done,
    input  logic        tick_100us,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic        irq,
    output logic [31:0] status_word
);
    localparam int CMP_W = (CNT_W > LIM_W) ? CNT_W : LIM_W;

    logic [TAG_W-1:0] tag;
    logic             fired;
    logic             en;
    logic             blk_rst;
    logic [LIM_W-1:0] cnt_lim;
    logic [LIM_W-1:0] time_lim;
    logic             ack_ok;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             lnk;
    logic             pending;
    logic             timeout;
    logic             fire_cond;

    icc_regs #(
        .TAG_W        (TAG_W),
        .LIM_W        (LIM_W),
        .DEF_CNT_LIM  (DEF_CNT_LIM),
        .DEF_TIME_LIM (DEF_TIME_LIM)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .cur_tag  (tag),
        .en       (en),
        .blk_rst  (blk_rst),
        .cnt_lim  (cnt_lim),
        .time_lim (time_lim),
        .ack_ok   (ack_ok)
    );

    icc_batch_counter #(
        .CNT_W (CNT_W)
    ) u_batch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (blk_rst),
        .restart (ack_ok),
        .hold    (fired),
        .msg     (msg_done),
        .lnk_evt (link_done),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt),
        .lnk     (lnk)
    );

    assign pending = (cnt != '0) || lnk;

    icc_timeout #(
        .LIM_W (LIM_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (blk_rst || ack_ok || fired),
        .run     (pending && !fired),
        .tick    (tick_100us),
        .lnk     (lnk),
        .tlim    (time_lim),
        .timeout (timeout)
    );

    // Firing decision: count limit reached by the next count, or timer expiry
    always_comb begin
        fire_cond = !blk_rst &&
                    (((cnt_nxt != '0) && (CMP_W'(cnt_nxt) >= CMP_W'(cnt_lim))) ||
                     (timeout && !ack_ok));
    end

    // Fired state: set on a firing decision, cleared by acknowledge or reset
    always_ff @(posedge clk) begin
        if (!rst_n || blk_rst)
            fired <= 1'b0;
        else if (ack_ok)
            fired <= fire_cond;
        else
            fired <= fired || fire_cond;
    end

    // Rolling tag: advances by one on each accepted acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n || blk_rst)
            tag <= '0;
        else if (ack_ok)
            tag <= tag + 1'b1;
    end

    // Outputs: gated interrupt and status word assembly
    always_comb begin
        irq                       = fired && en;
        status_word               = '0;
        status_word[TAG_W-1:0]    = tag;
        status_word[TAG_W+:CNT_W] = cnt;
        status_word[ICC_LINK_BIT] = lnk;
    end
endmodule

// File: rtl/irq_coalesce_chk.sv
// Module: property checker for the interrupt coalescer, bound to the top.
// Observes ports plus the fired state and block-reset control bit.
module irq_coalesce_chk #(
    parameter int CNT_W = 7,
    parameter int TAG_W = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        msg_done,
    input logic        link_done,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        irq,
    input logic [31:0] status_word,
    input logic        fired,
    input logic        blk_rst
);
    logic [TAG_W-1:0] s_tag;
    logic [CNT_W-1:0] s_cnt;
    logic             s_lnk;
    logic             ack_wr;
    logic             ack_match;

    assign s_tag     = status_word[TAG_W-1:0];
    assign s_cnt     = status_word[TAG_W+:CNT_W];
    assign s_lnk     = status_word[16];
    assign ack_wr    = reg_wr && (reg_addr == 2'd3);
    assign ack_match = (reg_wdata[TAG_W-1:0] == TAG_W'(s_tag + 1'b1));

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fired && !blk_rst && !(ack_wr && ack_match) |=> $stable(status_word)); // R7

    AST_BAD_ACK_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !blk_rst && ack_wr && !ack_match |=> irq); // R9

    AST_ACK_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr && ack_match && !blk_rst && !msg_done && !link_done
        |=> !irq && (s_cnt == '0) && !s_lnk); // R8

    AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(blk_rst) && (s_tag != $past(s_tag))
        |-> s_tag == TAG_W'($past(s_tag) + 1'b1)); // R8

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (s_cnt != '0) || s_lnk); // R5

    AST_BLKRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        blk_rst |=> !irq && (status_word == 32'h0)); // R11
endmodule

bind irq_coalesce_ctrl irq_coalesce_chk #(
    .CNT_W (CNT_W),
    .TAG_W (TAG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_done    (msg_done),
    .link_done   (link_done),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .irq         (irq),
    .status_word (status_word),
    .fired       (fired),
    .blk_rst     (blk_rst)
);

// File: tb/tb_irq_coalesce_ctrl.sv
// Bench: vector table walk followed by directed reset and corner-case tests.
module tb_irq_coalesce_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_done = 1'b0;
    logic        link_done = 1'b0;
    logic        tick_100us = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic        irq;
    logic [31:0] status_word;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_coalesce_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .msg_done    (msg_done),
        .link_done   (link_done),
        .tick_100us  (tick_100us),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .irq         (irq),
        .status_word (status_word)
    );

    typedef struct packed {
        logic        msg;
        logic        lnk;
        logic        tick;
        logic        we;
        logic [1:0]  adr;
        logic [31:0] dat;
        logic        eirq;
        logic [31:0] est;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b0,1'b1,2'd1,32'h0002_0000,1'b0,32'h0000_0000,8'd11}, // R11 leave block reset
        '{1'b0,1'b0,1'b0,1'b1,2'd0,32'h0004_0000,1'b0,32'h0000_0000,8'd10}, // R10 enable
        '{1'b0,1'b0,1'b0,1'b1,2'd2,32'h0000_0302,1'b0,32'h0000_0000,8'd13}, // R13 limits 2 msgs, 3 ticks
        '{1'b1,1'b0,1'b0,1'b0,2'd0,32'h0,        1'b0,32'h0000_0010,8'd4},  // R4 first message
        '{1'b1,1'b0,1'b0,1'b0,2'd0,32'h0,        1'b1,32'h0000_0020,8'd4},  // R4 limit reached
        '{1'b1,1'b0,1'b0,1'b0,2'd0,32'h0,        1'b1,32'h0000_0020,8'd7},  // R7 message ignored
        '{1'b0,1'b1,1'b0,1'b0,2'd0,32'h0,        1'b1,32'h0000_0020,8'd7},  // R7 link ignored
        '{1'b0,1'b0,1'b0,1'b1,2'd3,32'h0000_0005,1'b1,32'h0000_0020,8'd9},  // R9 wrong tag
        '{1'b0,1'b0,1'b0,1'b1,2'd3,32'h0000_0001,1'b0,32'h0000_0001,8'd8},  // R8 good ack
        '{1'b1,1'b0,1'b0,1'b0,2'd0,32'h0,        1'b0,32'h0000_0011,8'd5},  // R5 batch starts
        '{1'b0,1'b0,1'b1,1'b0,2'd0,32'h0,        1'b0,32'h0000_0011,8'd5},  // R5 tick 1
        '{1'b0,1'b0,1'b1,1'b0,2'd0,32'h0,        1'b0,32'h0000_0011,8'd5},  // R5 tick 2
        '{1'b0,1'b0,1'b1,1'b0,2'd0,32'h0,        1'b1,32'h0000_0011,8'd5},  // R5 tick 3 fires
        '{1'b0,1'b0,1'b0,1'b1,2'd1,32'h0004_0000,1'b0,32'h0000_0011,8'd10}, // R10 hide
        '{1'b0,1'b0,1'b0,1'b1,2'd0,32'h0004_0000,1'b1,32'h0000_0011,8'd10}, // R10 show again
        '{1'b0,1'b0,1'b0,1'b1,2'd1,32'hFFF9_FFFF,1'b1,32'h0000_0011,8'd3},  // R3 other bits inert
        '{1'b0,1'b0,1'b0,1'b1,2'd3,32'hFFFF_FFF2,1'b0,32'h0000_0002,8'd8},  // R8 upper bits ignored
        '{1'b0,1'b1,1'b0,1'b0,2'd0,32'h0,        1'b0,32'h0001_0002,8'd6},  // R6 link alone
        '{1'b0,1'b0,1'b1,1'b0,2'd0,32'h0,        1'b1,32'h0001_0002,8'd6},  // R6 next tick fires
        '{1'b1,1'b0,1'b0,1'b1,2'd3,32'h0000_0003,1'b0,32'h0000_0013,8'd14}, // R14 msg with ack
        '{1'b0,1'b1,1'b0,1'b0,2'd0,32'h0,        1'b0,32'h0001_0013,8'd1},  // R1 count and link
        '{1'b1,1'b0,1'b0,1'b0,2'd0,32'h0,        1'b1,32'h0001_0023,8'd1},  // R1 fired layout
        '{1'b0,1'b0,1'b0,1'b1,2'd3,32'h0000_0004,1'b0,32'h0000_0004,8'd8},  // R8 ack
        '{1'b1,1'b0,1'b1,1'b0,2'd0,32'h0,        1'b0,32'h0000_0014,8'd5},  // R5 tick with first msg
        '{1'b0,1'b0,1'b1,1'b0,2'd0,32'h0,        1'b0,32'h0000_0014,8'd5},  // R5 tick 1
        '{1'b0,1'b0,1'b1,1'b0,2'd0,32'h0,        1'b0,32'h0000_0014,8'd5},  // R5 tick 2
        '{1'b0,1'b0,1'b1,1'b0,2'd0,32'h0,        1'b1,32'h0000_0014,8'd5}   // R5 tick 3 fires
    };

    task automatic step(input logic m, input logic l, input logic t,
                        input logic w, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        msg_done = m; link_done = l; tick_100us = t;
        reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #2;
        msg_done = 1'b0; link_done = 1'b0; tick_100us = 1'b0;
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 32'h0;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic chk(input int req, input logic eirq, input logic [31:0] est);
        checks++;
        if (irq !== eirq || status_word !== est) begin
            errors++;
            $display("FAIL R%0d: irq=%0b status=%h expected irq=%0b status=%h",
                     req, irq, status_word, eirq, est);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run still going, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        idle();
        chk(2, 1'b0, 32'h0);                        // R2 reset state
        step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0);
        chk(2, 1'b0, 32'h0);                        // R2 block reset held by default

        foreach (TBL[i]) begin
            step(TBL[i].msg, TBL[i].lnk, TBL[i].tick, TBL[i].we, TBL[i].adr, TBL[i].dat);
            chk(int'(TBL[i].req), TBL[i].eirq, TBL[i].est);
        end

        // R11: block reset clears and holds everything
        step(1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 32'h0002_0000);
        chk(11, 1'b1, 32'h0000_0014);               // R11 not yet applied
        idle();
        chk(11, 1'b0, 32'h0);                       // R11 cleared
        step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0);
        chk(11, 1'b0, 32'h0);                       // R11 events ignored
        step(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 32'h1);
        chk(11, 1'b0, 32'h0);                       // R11 ack ignored
        step(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 32'h0002_0000);
        chk(11, 1'b0, 32'h0);                       // R11 released, tag zero

        // R12: count saturation with large limits
        step(1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 32'h0000_FFC8);
        for (int k = 0; k < 130; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
        chk(12, 1'b0, 32'h0000_07F0);               // R12 saturated at 127
        step(1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 32'h0000_FF00);
        idle();
        chk(4, 1'b1, 32'h0000_07F0);                // R4 lowered limit fires
        step(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 32'h1);
        chk(8, 1'b0, 32'h0000_0001);                // R8 rearm

        // R4: count limit zero fires on first message
        step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
        chk(4, 1'b1, 32'h0000_0011);                // R4 limit zero
        step(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 32'h2);
        chk(8, 1'b0, 32'h0000_0002);                // R8 ack

        // R8: tag wrap
        for (int t = 3; t < 16; t++) step(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 32'(t));
        chk(8, 1'b0, 32'h0000_000F);                // R8 tag 15
        step(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 32'h0);
        chk(8, 1'b0, 32'h0000_0000);                // R8 wrap to 0

        // R2: default limits after a fresh reset
        @(negedge clk) rst_n = 1'b0;
        idle();
        @(negedge clk) rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 32'h0002_0000);
        step(1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 32'h0004_0000);
        for (int k = 0; k < 15; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
        chk(2, 1'b0, 32'h0000_00F0);                // R2 below default count limit
        step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
        chk(2, 1'b1, 32'h0000_0100);                // R2 16 messages fire
        step(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 32'h1);
        step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
        chk(2, 1'b0, 32'h0000_0011);                // R2 new batch
        for (int k = 0; k < 9; k++) step(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0);
        chk(2, 1'b0, 32'h0000_0011);                // R2 nine ticks
        step(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0);
        chk(2, 1'b1, 32'h0000_0011);                // R2 tenth tick fires

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule